// File: doc/BRIEF.md
# Serial Peripheral Master with Register Interface

This block is a single-channel serial peripheral (SPI) master. Software reaches it through a small word-wide register interface. A mode register holds the enable, master-select, bit-order and loopback controls, a four-bit clock prescaler and a four-bit character-length code. A write to the transmit register queues one character of 4 to 32 bits. The shift engine then produces SCK, drives MOSI and samples MISO. When the last bit has been sampled, the received character is placed in the receive register, right-justified, and two sticky status events are raised.

The status events are receiver-not-empty and transmitter-not-full. Software clears them by writing ones. A mask register selects which events drive the interrupt line. The transmit register is one character deep: a write made while a character is shifting is held, and that character is sent as soon as the current one finishes. Chip select is outside the block and is driven by software.

Register addresses on `reg_addr`: 0 = mode, 1 = event, 2 = mask, 3 = transmit, 4 = receive.

Top module: `spim_core`

## Requirements
- R1: After reset the mode and mask registers read 0, the event register reads 0x0000_0100 (transmitter-not-full set), SCK is low and `irq` is low.
- R2: SCK idles low. While a character is shifting, one SCK period is 4 × (P + 1) system clocks, where P is mode bits 19:16. P = 1 therefore gives the system clock divided by 8.
- R3: Mode bits 23:20 hold the length code L. L = 0 sends 32 bits and L ≥ 3 sends L + 1 bits. The invalid codes 1 and 2 are treated as 4 bits. The number of SCK pulses equals the character length.
- R4: With mode bit 26 clear, the character is shifted LSB first. MOSI changes only on falling SCK edges, and MISO is sampled on rising edges.
- R5: With mode bit 26 set, bit (length − 1) of the character is shifted first and bit 0 last.
- R6: The receive register (address 4) holds the received character right-justified, with every bit above the character length reading 0. Transmit bits above the character length are not sent.
- R7: With mode bit 30 set, the receiver takes the block's own serial output instead of MISO, so the receive register returns the transmitted character.
- R8: Event bit 9 (receiver-not-empty) and event bit 8 (transmitter-not-full) are both set at the clock edge where the last bit of a character is sampled. The receive register updates at that same edge.
- R9: Writing a 1 to an event bit clears it. A 0 leaves the bit unchanged. Writing 0xFFFF_FFFF clears both events.
- R10: `irq` is high exactly when (event bit 9 AND mask bit 9) OR (event bit 8 AND mask bit 8). A mask of zero holds `irq` low.
- R11: A transmit write while mode bit 24 (enable) or mode bit 25 (master) is clear is ignored: no SCK pulse and no event follows.
- R12: A transmit write made while a character is shifting is held and sent right after it. Both characters are received in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Masked event interrupt |

## Verification
The bench builds the block with its default parameters: a four-bit prescaler and a 32-bit data word. The prescaler and length code are run-time fields, so prescaler values 0, 1 and 3 and length codes 0, 1, 3, 7, 11 and 15 are all reached without rebuilding. This covers the shortest and longest characters, the clamp applied to invalid codes, and three distinct SCK periods. Both bit orders run against a modelled slave, and loopback runs with MISO held high.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int WORD_W   = 32;
  localparam int LCODE_W  = 4;
  localparam int CLEN_W   = 6;
  localparam int MIN_CHAR = 4;

  localparam int B_LOOP  = 30;
  localparam int B_MSBF  = 26;
  localparam int B_MSTR  = 25;
  localparam int B_EN    = 24;
  localparam int B_LEN_L = 20;
  localparam int B_PRE_L = 16;
  localparam int B_RXNE  = 9;
  localparam int B_TXNF  = 8;

  localparam logic [2:0] A_MODE  = 3'd0;
  localparam logic [2:0] A_EVENT = 3'd1;
  localparam logic [2:0] A_MASK  = 3'd2;
  localparam logic [2:0] A_TX    = 3'd3;
  localparam logic [2:0] A_RX    = 3'd4;

  function automatic logic [CLEN_W-1:0] char_len(input logic [LCODE_W-1:0] code);
    if (code == '0) return CLEN_W'(WORD_W);
    else if (int'(code) + 1 < MIN_CHAR) return CLEN_W'(MIN_CHAR);
    else return CLEN_W'(int'(code) + 1);
  endfunction

  function automatic int half_period(input int pre);
    return 2 * (pre + 1);
  endfunction

  function automatic logic [WORD_W-1:0] len_mask(input logic [CLEN_W-1:0] len);
    logic [2*WORD_W-1:0] one;
    one = 1;
    return WORD_W'((one << len) - 1);
  endfunction

  function automatic logic [WORD_W-1:0] tx_align(input logic [WORD_W-1:0] d,
                                                 input logic [CLEN_W-1:0] len,
                                                 input logic msb_first);
    if (msb_first) return d << (WORD_W - int'(len));
    else return d;
  endfunction

  function automatic logic [WORD_W-1:0] rx_justify(input logic [WORD_W-1:0] raw,
                                                   input logic [CLEN_W-1:0] len,
                                                   input logic msb_first);
    if (msb_first) return raw & len_mask(len);
    else return raw >> (WORD_W - int'(len));
  endfunction
endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  localparam int CNT_W = PRE_W + 2;

  logic [CNT_W-1:0] half_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= CNT_W'(2);
      cnt_q  <= '0;
    end else begin
      if (restart) half_q <= CNT_W'(spim_pkg::half_period(int'(pre)));
      if (restart || !run || tick) cnt_q <= '0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q == half_q - 1'b1);

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < half_q);
  p_tick_spaced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WORD_W-1:0]  tx_data,
  input  logic [LCODE_W-1:0] len_code,
  input  logic               msb_first,
  input  logic               loop_en,
  input  logic               miso,
  input  logic               tick,
  output logic               busy,
  output logic               sck,
  output logic               mosi,
  output logic               last_cap,
  output logic [WORD_W-1:0]  rx_word
);
  logic                busy_q, tail_q, sck_q, msb_q, loop_q;
  logic [CLEN_W-1:0]   len_q, bitcnt_q;
  logic [WORD_W-1:0]   sr_tx_q, sr_rx_q, rx_shift;
  logic                in_bit;

  assign mosi     = msb_q ? sr_tx_q[WORD_W-1] : sr_tx_q[0];
  assign in_bit   = loop_q ? mosi : miso;
  assign rx_shift = msb_q ? {sr_rx_q[WORD_W-2:0], in_bit} : {in_bit, sr_rx_q[WORD_W-1:1]};
  assign last_cap = busy_q && tick && !tail_q && !sck_q && (bitcnt_q == len_q - 1'b1);
  assign rx_word  = rx_justify(rx_shift, len_q, msb_q);
  assign busy     = busy_q;
  assign sck      = sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      tail_q   <= 1'b0;
      sck_q    <= 1'b0;
      msb_q    <= 1'b0;
      loop_q   <= 1'b0;
      len_q    <= CLEN_W'(WORD_W);
      bitcnt_q <= '0;
      sr_tx_q  <= '0;
      sr_rx_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q   <= 1'b1;
        tail_q   <= 1'b0;
        sck_q    <= 1'b0;
        msb_q    <= msb_first;
        loop_q   <= loop_en;
        len_q    <= char_len(len_code);
        bitcnt_q <= '0;
        sr_tx_q  <= tx_align(tx_data, char_len(len_code), msb_first);
        sr_rx_q  <= '0;
      end
    end else if (tick) begin
      if (tail_q) begin
        sck_q  <= 1'b0;
        busy_q <= 1'b0;
        tail_q <= 1'b0;
      end else if (!sck_q) begin
        sck_q    <= 1'b1;
        sr_rx_q  <= rx_shift;
        bitcnt_q <= bitcnt_q + 1'b1;
        if (last_cap) tail_q <= 1'b1;
      end else begin
        sck_q   <= 1'b0;
        sr_tx_q <= msb_q ? {sr_tx_q[WORD_W-2:0], 1'b0} : {1'b0, sr_tx_q[WORD_W-1:1]};
      end
    end
  end

  p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sck_q);
  p_bits_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (bitcnt_q <= len_q));
  p_len_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (len_q >= CLEN_W'(MIN_CHAR)));
  p_mosi_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tail_q && $past(busy_q) && !$fell(sck_q)) |-> $stable(mosi));
endmodule

// File: rtl/spim_core.sv
module spim_core
  import spim_pkg::*;
#(
  parameter int PRE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [2:0]         reg_addr,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  output logic               sck,
  output logic               mosi,
  input  logic               miso,
  output logic               irq
);
  logic               m_loop, m_msbf, m_mstr, m_en;
  logic [LCODE_W-1:0] m_len;
  logic [PRE_W-1:0]   m_pre;
  logic               ev_ne, ev_nf, mk_ne, mk_nf;
  logic [WORD_W-1:0]  tx_q, rx_q;
  logic               tx_pend;

  logic               busy, tick, last_cap, start;
  logic [WORD_W-1:0]  rx_word;
  logic               wr_mode, wr_event, wr_mask, wr_tx, tx_accept;

  assign wr_mode   = reg_wr && (reg_addr == A_MODE);
  assign wr_event  = reg_wr && (reg_addr == A_EVENT);
  assign wr_mask   = reg_wr && (reg_addr == A_MASK);
  assign wr_tx     = reg_wr && (reg_addr == A_TX);
  assign tx_accept = wr_tx && m_en && m_mstr;
  assign start     = tx_pend && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_loop <= 1'b0; m_msbf <= 1'b0; m_mstr <= 1'b0; m_en <= 1'b0;
      m_len  <= '0;   m_pre  <= '0;
      ev_ne  <= 1'b0; ev_nf  <= 1'b1;
      mk_ne  <= 1'b0; mk_nf  <= 1'b0;
      tx_q   <= '0;   rx_q   <= '0;
      tx_pend <= 1'b0;
    end else begin
      if (wr_mode) begin
        m_loop <= reg_wdata[B_LOOP];
        m_msbf <= reg_wdata[B_MSBF];
        m_mstr <= reg_wdata[B_MSTR];
        m_en   <= reg_wdata[B_EN];
        m_len  <= reg_wdata[B_LEN_L +: LCODE_W];
        m_pre  <= reg_wdata[B_PRE_L +: PRE_W];
      end
      if (wr_mask) begin
        mk_ne <= reg_wdata[B_RXNE];
        mk_nf <= reg_wdata[B_TXNF];
      end
      ev_ne <= last_cap || (ev_ne && !(wr_event && reg_wdata[B_RXNE]));
      ev_nf <= last_cap || (ev_nf && !(wr_event && reg_wdata[B_TXNF]));
      if (last_cap) rx_q <= rx_word;
      if (tx_accept) tx_q <= reg_wdata;
      if (tx_accept) tx_pend <= 1'b1;
      else if (start) tx_pend <= 1'b0;
    end
  end

  spim_clkdiv #(.PRE_W(PRE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(start), .run(busy), .pre(m_pre), .tick(tick)
  );

  spim_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_data(tx_q), .len_code(m_len),
    .msb_first(m_msbf), .loop_en(m_loop), .miso(miso), .tick(tick),
    .busy(busy), .sck(sck), .mosi(mosi), .last_cap(last_cap), .rx_word(rx_word)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MODE: begin
        reg_rdata[B_LOOP] = m_loop;
        reg_rdata[B_MSBF] = m_msbf;
        reg_rdata[B_MSTR] = m_mstr;
        reg_rdata[B_EN]   = m_en;
        reg_rdata[B_LEN_L +: LCODE_W] = m_len;
        reg_rdata[B_PRE_L +: PRE_W]   = m_pre;
      end
      A_EVENT: begin
        reg_rdata[B_RXNE] = ev_ne;
        reg_rdata[B_TXNF] = ev_nf;
      end
      A_MASK: begin
        reg_rdata[B_RXNE] = mk_ne;
        reg_rdata[B_TXNF] = mk_nf;
      end
      A_TX:    reg_rdata = tx_q;
      A_RX:    reg_rdata = rx_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = (ev_ne && mk_ne) || (ev_nf && mk_nf);

  p_mask_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mk_ne && !mk_nf) |-> !irq);
  p_both_events_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_cap |=> (ev_ne && ev_nf));
  p_w1c_ne_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_event && reg_wdata[B_RXNE] && !last_cap) |=> !ev_ne);
  p_w1c_nf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_event && reg_wdata[B_TXNF] && !last_cap) |=> !ev_nf);
  p_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && !(m_en && m_mstr) && !tx_pend && !busy) |=> !busy);
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pend && busy) |=> tx_pend);
endmodule

// File: tb/spim_core_test.sv
module spim_core_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sck, mosi, irq;
  logic        miso = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int rises = 0;

  typedef struct {
    logic [31:0] tx;
    logic [31:0] slv;
    int          len;
    bit          msbf;
    int          pre;
  } item_t;
  item_t sb_q[$];

  spim_core uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_len(input int code);
    if (code == 0) return 32;
    if (code < 3) return 4;
    return code + 1;
  endfunction

  function automatic logic [31:0] keep_low(input logic [31:0] v, input int n);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < n; i++) r[i] = v[i];
    return r;
  endfunction

  function automatic int bitpos(input int k, input int n, input bit msbf);
    return msbf ? (n - 1 - k) : k;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_ne(input string req);
    logic [31:0] ev;
    for (int i = 0; i < 5000; i++) begin
      rd(3'd1, ev);
      if (ev[9]) return;
    end
    check(req, 32'h0, 32'h200);
  endtask

  function automatic logic [31:0] mode_word(input bit loop, input bit msbf, input int code, input int pre);
    logic [31:0] m;
    m = '0;
    m[30] = loop; m[26] = msbf; m[25] = 1'b1; m[24] = 1'b1;
    m[23:20] = 4'(code); m[19:16] = 4'(pre);
    return m;
  endfunction

  // driver: configure, push expected serial item, start, then check receive register
  task automatic xfer(input string req, input bit loop, input bit msbf, input int code,
                      input int pre, input logic [31:0] tx, input logic [31:0] slv);
    item_t it;
    logic [31:0] rxv, expv;
    it.tx = tx; it.slv = slv; it.len = exp_len(code); it.msbf = msbf; it.pre = pre;
    wr(3'd0, mode_word(loop, msbf, code, pre));
    wr(3'd1, 32'hFFFF_FFFF);
    miso = loop ? 1'b1 : slv[bitpos(0, it.len, msbf)];
    sb_q.push_back(it);
    wr(3'd3, tx);
    wait_ne(req);
    rd(3'd4, rxv);
    expv = keep_low(loop ? tx : slv, it.len);
    check(req, rxv, expv);
  endtask

  // monitor: rebuild the MOSI word bit by bit and compare with the queued item
  int          mon_cnt = 0;
  logic [31:0] mon_word;
  time         mon_last;
  bit          mon_per_bad;
  always @(posedge sck) begin
    rises++;
    if (sb_q.size() == 0) begin
      check("R11 unexpected SCK", 32'h1, 32'h0);
    end else begin
      if (mon_cnt == 0) begin
        mon_word = '0;
        mon_per_bad = 0;
      end else if ($time - mon_last != time'(4 * (sb_q[0].pre + 1) * CLK_PERIOD)) begin
        mon_per_bad = 1;
      end
      mon_last = $time;
      mon_word[bitpos(mon_cnt, sb_q[0].len, sb_q[0].msbf)] = mosi;
      mon_cnt++;
      if (mon_cnt == sb_q[0].len) begin
        check(sb_q[0].msbf ? "R5 MOSI order" : "R4 MOSI order",
              mon_word, keep_low(sb_q[0].tx, sb_q[0].len));
        check("R2 SCK period", 32'(mon_per_bad), 32'h0);
        void'(sb_q.pop_front());
        mon_cnt = 0;
      end
    end
  end

  // slave model: next MISO bit on each falling SCK edge
  always @(negedge sck) begin
    if (sb_q.size() != 0 && mon_cnt != 0 && mon_cnt < sb_q[0].len)
      miso = sb_q[0].slv[bitpos(mon_cnt, sb_q[0].len, sb_q[0].msbf)];
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd0, v); check("R1 mode", v, 32'h0);
    rd(3'd1, v); check("R1 event", v, 32'h100);
    rd(3'd2, v); check("R1 mask", v, 32'h0);
    check("R1 sck/irq", {30'b0, sck, irq}, 32'h0);

    // R2 R4: LSB first, prescaler 1 gives /8, 8-bit character
    xfer("R4 rx lsb8", 0, 0, 7, 1, 32'h0000_00A5, 32'h0000_003C);
    // R5: MSB first, 12 bits, prescaler 0
    xfer("R5 rx msb12", 0, 1, 11, 0, 32'h0000_0ABC, 32'h0000_05A3);
    // R3: code 0 is 32 bits, prescaler 3
    xfer("R3 rx len32", 0, 1, 0, 3, 32'hDEAD_BEEF, 32'h1234_5678);
    // R3 R6: shortest character, upper bits neither sent nor received
    xfer("R6 rx len4", 0, 0, 3, 0, 32'hFFFF_FFF3, 32'hFFFF_FFF9);
    // R3: invalid code 1 clamps to 4 bits
    xfer("R3 rx clamp", 0, 1, 1, 0, 32'h0000_0006, 32'hFFFF_FFFA);
    xfer("R3 rx len16", 0, 0, 15, 1, 32'h0000_C3A1, 32'h0000_7E11);
    // R7: loopback ignores MISO (held high)
    xfer("R7 loopback", 1, 0, 15, 0, 32'h0000_1234, 32'hFFFF_FFFF);

    // R8 both events; R10 irq masking; R9 write-one-to-clear
    rd(3'd1, v); check("R8 events", v, 32'h300);
    @(negedge clk); check("R10 mask zero", 32'(irq), 32'h0);
    wr(3'd2, 32'h200); @(negedge clk); check("R10 mask ne", 32'(irq), 32'h1);
    wr(3'd1, 32'h200); rd(3'd1, v); check("R9 clear ne", v, 32'h100);
    check("R10 irq off", 32'(irq), 32'h0);
    wr(3'd2, 32'h100); @(negedge clk); check("R10 mask nf", 32'(irq), 32'h1);
    wr(3'd1, 32'h0); rd(3'd1, v); check("R9 zero write", v, 32'h100);
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, v); check("R9 clear all", v, 32'h0);
    wr(3'd2, 32'h0);

    // R11: enable clear, then master clear
    r0 = rises;
    wr(3'd0, 32'h0200_0070);
    wr(3'd3, 32'h0000_0055);
    repeat (300) @(negedge clk);
    rd(3'd1, v); check("R11 no event en", v, 32'h0);
    check("R11 no sck en", 32'(rises - r0), 32'h0);
    wr(3'd0, 32'h0100_0070);
    wr(3'd3, 32'h0000_0055);
    repeat (300) @(negedge clk);
    rd(3'd1, v); check("R11 no event ms", v, 32'h0);
    check("R11 no sck ms", 32'(rises - r0), 32'h0);

    // R12: second write while busy is held and sent next (loopback)
    begin
      item_t a, b;
      a.tx = 32'h9; a.slv = '1; a.len = 8; a.msbf = 1; a.pre = 1;
      b = a; b.tx = 32'hC6;
      wr(3'd0, mode_word(1, 1, 7, 1));
      sb_q.push_back(a); sb_q.push_back(b);
      wr(3'd3, a.tx);
      wr(3'd3, b.tx);
      wait_ne("R12 first");
      rd(3'd4, v); check("R12 first rx", v, 32'h09);
      wr(3'd1, 32'hFFFF_FFFF);
      wait_ne("R12 second");
      rd(3'd4, v); check("R12 second rx", v, 32'hC6);
      repeat (40) @(negedge clk);
      check("R12 queue drained", 32'(sb_q.size()), 32'h0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule